// File: doc/BRIEF.md
# Vessel Boarding Capacity Limiter

This block sits between the entrance turnstiles of a passenger vessel and their locking mechanism. Every passage through a turnstile raises a pulse on the passage input. The block counts these passages and, once the configured capacity has boarded, it drives a lock output that stops the turnstile from turning.

The lock stays on, and further passage pulses are discarded, until a pulse from the pier sensor reports that the vessel has left. That departure pulse releases the lock and also sets the tally back to zero for the next trip.

Passage pulses are edge-detected, so a pulse lasting several clock cycles counts as one person. A departure that lands in the same cycle as a new passage edge takes precedence, and the passage is not counted. The capacity is a parameter with a default of 230.

Top module: `boardlim_top`

## Requirements
- R1: Each 0-to-1 transition of `pass_i`, seen at a clock edge, adds exactly one person to the tally. A `pass_i` held high for several cycles adds one person only.
- R2: `lock_o` is 0 while the tally is below CAPACITY. It reads 1 from the cycle after the clock edge that counts the CAPACITY-th passage.
- R3: While `lock_o` is 1 and `depart_i` is low, passage edges are ignored, the tally never exceeds CAPACITY, and `lock_o` stays 1.
- R4: `depart_i` high at a clock edge releases the lock: `lock_o` reads 0 from the following cycle.
- R5: When `depart_i` is high at the same edge as a new passage edge, the tally becomes zero and that passage is not counted. A full CAPACITY of further passages is then needed to lock.
- R6: A synchronous active-high `rst` clears the tally to zero and drives `lock_o` to 0.
- R7: A departure below capacity discards the partial tally. CAPACITY new passages are needed to lock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pass_i | input | 1 | Turnstile passage pulse, one per person |
| depart_i | input | 1 | Pier departure pulse; releases the lock and clears the tally |
| lock_o | output | 1 | Turnstile lock, 1 when capacity has been reached |

## Verification
The bench checks that a passage pulse held for several cycles counts as one person. A design that counted levels would lock after too few people. It drives surplus passages into a locked turnstile and then counts the passages needed after departure. A tally that overflowed, or that kept counting behind the lock, would lock early or late on the next trip. It lands a departure in the same cycle as a passage edge, where a design that gave the passage priority would lock one person short. It also checks departures and resets on a partial tally, which would expose a leftover count.

// File: rtl/boardlim_pkg.sv
package boardlim_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_CLEAR = 2'd2
    } tally_act_e;

    function automatic int tally_width(input int cap);
        return $clog2(cap + 1);
    endfunction

endpackage

// File: rtl/boardlim_edge.sv
module boardlim_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;

    // A level held high gives a single rise (R1)
    assert_single_rise_R1: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/boardlim_arbiter.sv
module boardlim_arbiter
    import boardlim_pkg::*;
(
    input  logic       depart_i,
    input  logic       rise_i,
    input  logic       full_i,
    output tally_act_e act_o
);
    always_comb begin
        if (depart_i)              act_o = ACT_CLEAR;
        else if (rise_i && !full_i) act_o = ACT_STEP;
        else                        act_o = ACT_HOLD;
    end
endmodule

// File: rtl/boardlim_tally.sv
module boardlim_tally
    import boardlim_pkg::*;
#(
    parameter int CAPACITY = 230
) (
    input  logic       clk,
    input  logic       rst,
    input  tally_act_e act_i,
    input  logic       depart_i,
    output logic       full_o
);
    localparam int CNT_W = tally_width(CAPACITY);
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act_i)
                ACT_CLEAR: cnt_q <= '0;
                ACT_STEP:  cnt_q <= cnt_q + 1'b1;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    assign full_o = (cnt_q == CAP_V);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CAP_V);

    assert_lock_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (full_o && !depart_i) |=> full_o);

    assert_depart_release_R4: assert property (@(posedge clk) disable iff (rst)
        depart_i |=> (cnt_q == '0));

    assert_step_one_R1: assert property (@(posedge clk) disable iff (rst)
        !depart_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> (cnt_q == '0));
endmodule

// File: rtl/boardlim_top.sv
module boardlim_top
    import boardlim_pkg::*;
#(
    parameter int CAPACITY = 230
) (
    input  logic clk,
    input  logic rst,
    input  logic pass_i,
    input  logic depart_i,
    output logic lock_o
);
    logic       rise;
    logic       full;
    tally_act_e act;

    boardlim_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (pass_i),
        .rise_o  (rise)
    );

    boardlim_arbiter u_arb (
        .depart_i (depart_i),
        .rise_i   (rise),
        .full_i   (full),
        .act_o    (act)
    );

    boardlim_tally #(.CAPACITY(CAPACITY)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .act_i    (act),
        .depart_i (depart_i),
        .full_o   (full)
    );

    assign lock_o = full;

    // Departure together with a passage edge never leaves the tally stepped (R5)
    assert_depart_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (depart_i && rise) |-> (act == ACT_CLEAR));
endmodule

// File: tb/tb_boardlim_top.sv
`timescale 1ns/1ps
module tb_boardlim_top;
    localparam int CAP = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pass_i = 1'b0;
    logic depart_i = 1'b0;
    logic lock_o;

    int total = 0;
    int bad = 0;

    int  m_cnt = 0;
    bit  m_prev = 1'b0;

    boardlim_top #(.CAPACITY(CAP)) dut (
        .clk(clk), .rst(rst), .pass_i(pass_i), .depart_i(depart_i), .lock_o(lock_o)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_cnt  <= 0;
            m_prev <= 1'b0;
        end else begin
            m_prev <= pass_i;
            if (depart_i) m_cnt <= 0;
            else if (pass_i && !m_prev && m_cnt < CAP) m_cnt <= m_cnt + 1;
        end
    end

    task automatic check(input bit got, input bit exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: lock_o=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // compare against the model every cycle
    always @(negedge clk) begin
        if (!rst) check(lock_o, (m_cnt == CAP), "model R2/R3/R4");
    end

    task automatic passage(input int len);
        @(negedge clk) pass_i = 1'b1;
        for (int i = 1; i < len; i++) @(negedge clk);
        @(negedge clk) pass_i = 1'b0;
    endtask

    task automatic passages(input int n);
        for (int i = 0; i < n; i++) passage(1);
    endtask

    task automatic depart();
        @(negedge clk) depart_i = 1'b1;
        @(negedge clk) depart_i = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                check(lock_o, 1'b0, "R6 reset state");
                passages(CAP - 1);
                check(lock_o, 1'b0, "R2 below capacity");
                passages(1);
                check(lock_o, 1'b1, "R2 lock at capacity");
                passages(3);
                check(lock_o, 1'b1, "R3 lock held under passages");
                depart();
                check(lock_o, 1'b0, "R4 release on departure");
                passages(CAP - 1);
                check(lock_o, 1'b0, "R3 no overflow carried");
                passages(1);
                check(lock_o, 1'b1, "R3 relock after full trip");
                depart();
                passage(3); passage(4);
                passages(CAP - 3);
                check(lock_o, 1'b0, "R1 long pulses count once");
                passages(1);
                check(lock_o, 1'b1, "R1 lock after long pulses");
                depart();
                passages(3);
                depart();
                passages(CAP - 1);
                check(lock_o, 1'b0, "R7 partial tally discarded");
                passages(1);
                check(lock_o, 1'b1, "R7 lock after new trip");
                depart();
                passages(CAP - 1);
                @(negedge clk) begin pass_i = 1'b1; depart_i = 1'b1; end
                @(negedge clk) begin pass_i = 1'b0; depart_i = 1'b0; end
                check(lock_o, 1'b0, "R5 departure wins");
                passages(CAP - 1);
                check(lock_o, 1'b0, "R5 coincident passage not counted");
                passages(1);
                check(lock_o, 1'b1, "R5 lock after full count");
                depart();
                passages(3);
                @(negedge clk) rst = 1'b1;
                @(negedge clk) rst = 1'b0;
                check(lock_o, 1'b0, "R6 reset mid trip");
                passages(CAP - 1);
                check(lock_o, 1'b0, "R6 tally cleared by reset");
                passages(1);
                check(lock_o, 1'b1, "R6 lock after reset trip");
            end
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: expired expected completion");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule